// File: doc/BRIEF.md
# Genlock Mode and Lock-Status Controller

This block is the control core of a video clock and timing generator. It picks one of three operating modes: genlock, where output timing tracks an incoming reference; freeze (holdover), entered when that reference disappears while genlocked; and free run, where output timing comes from the local 27 MHz crystal. A mode pin held high forces free run. When the mode pin is low, the block leaves free run for genlock. It moves from freeze back to genlock only after the reference has been present for a programmable number of consecutive frames.

The block also watches the programmed horizontal offset against the sync-to-end-of-active-video count of the selected output standard. For blanking-based references, an offset beyond that count plus 20 raises a one-line advance request for all line-based timing outputs. An offset of exactly that count plus 21 pulls the vertical and field lock flags low, but the overall genlock flag stays asserted. A mask input suppresses this pull-down. The block packs all of these flags into an 8-bit lock status word and returns a registered copy of the sync-to-end-of-active-video count for status readback.

Top module: `gl_mode_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the mode output at free run (2'b10), clears line_advance and clears s2e_status to zero.
- R2: While free_run_pin is high at a clock edge, mode is 2'b10 (free run) after that edge, whatever the previous mode.
- R3: In free run with free_run_pin low at a clock edge, mode becomes 2'b00 (genlock) after that edge.
- R4: In genlock with free_run_pin low and ref_present low at a clock edge, mode becomes 2'b01 (freeze) after that edge.
- R5: In freeze, mode returns to 2'b00 only at the frame_tick edge that completes N consecutive frame_tick edges with ref_present high, where N is reacq_frames (0 acts as 1). Any edge with ref_present low restarts the count.
- R6: line_advance equals, one clock after the inputs are applied, blank_ref AND (h_offset > sync_to_eav + 20). Both operands are 13-bit unsigned and the sum is formed one bit wider so it cannot wrap.
- R7: With blank_ref high, lock_mask_en low and h_offset == sync_to_eav + 21 applied at an edge, lock_status bits 3 and 4 read 0 for the following cycle. In genlock, lock_status bit 0 still follows raw_genlock during that cycle.
- R8: When lock_mask_en was high at the edge, bits 3 and 4 follow raw_vlock and raw_flock in genlock even when the offset equals sync_to_eav + 21.
- R9: lock_status bit 3 (vertical lock) and bit 4 (field lock) read 0 outside genlock. Bit 1 reads 1 exactly in freeze. Bit 0 is raw_genlock gated by genlock mode. Bits 7..5 read 0.
- R10: lock_status bit 2 follows raw_audio_lock in every mode, free run included.
- R11: s2e_status equals sync_to_eav from the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| free_run_pin | input | 1 | High forces free-run mode |
| ref_present | input | 1 | Input reference detected |
| frame_tick | input | 1 | One-cycle pulse per reference frame |
| reacq_frames | input | 8 | Consecutive frames needed to leave freeze |
| blank_ref | input | 1 | Reference is blanking-based |
| h_offset | input | 13 | Programmed horizontal offset |
| sync_to_eav | input | 13 | Sync-to-end-of-active-video count of the standard |
| lock_mask_en | input | 1 | Keep lock flags high at the exact-offset point |
| raw_genlock | input | 1 | Raw overall genlock flag |
| raw_vlock | input | 1 | Raw vertical lock flag |
| raw_flock | input | 1 | Raw field lock flag |
| raw_audio_lock | input | 1 | Raw audio clock lock flag |
| mode | output | 2 | 00 genlock, 01 freeze, 10 free run |
| line_advance | output | 1 | Advance line-based outputs by one line |
| lock_status | output | 8 | Packed lock status word |
| s2e_status | output | 13 | Registered sync-to-end-of-active-video count |

## Verification
The line advance and the lock-flag pull-down can fire in the same cycle, because an offset of exactly the count plus 21 also exceeds the count plus 20. The bench steps h_offset through the count plus 19 to 23 in genlock, with blank_ref and lock_mask_en both high and low and the raw flags toggling. It then compares line_advance and every lock_status bit in that cycle against a behavioural model. The overall genlock bit must stay asserted while bits 3 and 4 drop.

// File: rtl/gl_ctrl_pkg.sv
package gl_ctrl_pkg;

    typedef enum logic [1:0] {
        MODE_GEN  = 2'b00,
        MODE_FRZ  = 2'b01,
        MODE_FREE = 2'b10
    } gl_mode_e;

    // status word layout (bits 3/4 fixed by consumers of the word)
    localparam int ST_W      = 8;
    localparam int ST_GEN    = 0;
    localparam int ST_HOLD   = 1;
    localparam int ST_AUD    = 2;
    localparam int ST_VLK    = 3;
    localparam int ST_FLK    = 4;

    typedef struct packed {
        logic adv;   // one-line advance request
        logic sup;   // suppress vertical/field lock flags
    } ofs_flags_t;

    // frames required to leave freeze; zero behaves as one
    function automatic logic [15:0] reacq_target(input logic [15:0] prog);
        return (prog == '0) ? 16'd1 : prog;
    endfunction

endpackage

// File: rtl/gl_mode_fsm.sv
module gl_mode_fsm
    import gl_ctrl_pkg::*;
#(
    parameter int FCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              free_pin,
    input  logic              ref_ok,
    input  logic              frame_tick,
    input  logic [FCNT_W-1:0] reacq_frames,
    output gl_mode_e          mode_q
);
    localparam int CW = FCNT_W + 1;

    gl_mode_e          mode_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [CW-1:0]     cnt_inc;
    logic [CW-1:0]     target;
    logic [15:0]       tgt16;

    assign tgt16   = reacq_target(16'(reacq_frames));
    assign target  = CW'(tgt16);
    assign cnt_inc = cnt_q + CW'(1);

    always_comb begin
        mode_d = mode_q;
        cnt_d  = cnt_q;
        if (free_pin) begin
            mode_d = MODE_FREE;
            cnt_d  = '0;
        end else begin
            unique case (mode_q)
                MODE_FREE: begin
                    mode_d = MODE_GEN;
                    cnt_d  = '0;
                end
                MODE_GEN: begin
                    cnt_d = '0;
                    if (!ref_ok) mode_d = MODE_FRZ;
                end
                MODE_FRZ: begin
                    if (!ref_ok) begin
                        cnt_d = '0;
                    end else if (frame_tick) begin
                        if (cnt_inc >= target) begin
                            mode_d = MODE_GEN;
                            cnt_d  = '0;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                default: begin
                    mode_d = MODE_FREE;
                    cnt_d  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_FREE;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
        end
    end

endmodule

// File: rtl/gl_offset_cmp.sv
module gl_offset_cmp
    import gl_ctrl_pkg::*;
#(
    parameter int OFS_W      = 13,
    parameter int ADV_MARGIN = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blank_ref,
    input  logic             mask_en,
    input  logic [OFS_W-1:0] h_offset,
    input  logic [OFS_W-1:0] s2e,
    output ofs_flags_t       flags_q,
    output logic [OFS_W-1:0] s2e_q
);
    localparam int SUM_W = OFS_W + 1;

    logic [SUM_W-1:0] thr_adv;
    logic [SUM_W-1:0] thr_hit;
    logic [SUM_W-1:0] ofs_w;
    ofs_flags_t       flags_d;

    assign ofs_w   = {1'b0, h_offset};
    assign thr_adv = {1'b0, s2e} + SUM_W'(ADV_MARGIN);
    assign thr_hit = thr_adv + SUM_W'(1);

    always_comb begin
        flags_d.adv = blank_ref && (ofs_w > thr_adv);
        flags_d.sup = blank_ref && (ofs_w == thr_hit) && !mask_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            s2e_q   <= '0;
        end else begin
            flags_q <= flags_d;
            s2e_q   <= s2e;
        end
    end

endmodule

// File: rtl/gl_status_pack.sv
module gl_status_pack
    import gl_ctrl_pkg::*;
(
    input  gl_mode_e        mode,
    input  logic            sup,
    input  logic            raw_genlock,
    input  logic            raw_vlock,
    input  logic            raw_flock,
    input  logic            raw_audio_lock,
    output logic [ST_W-1:0] status
);
    logic in_gen;
    assign in_gen = (mode == MODE_GEN);

    always_comb begin
        status          = '0;
        status[ST_GEN]  = raw_genlock && in_gen;
        status[ST_HOLD] = (mode == MODE_FRZ);
        status[ST_AUD]  = raw_audio_lock;
        status[ST_VLK]  = raw_vlock && in_gen && !sup;
        status[ST_FLK]  = raw_flock && in_gen && !sup;
    end

endmodule

// File: rtl/gl_mode_ctrl.sv
module gl_mode_ctrl
    import gl_ctrl_pkg::*;
#(
    parameter int OFS_W      = 13,
    parameter int FCNT_W     = 8,
    parameter int ADV_MARGIN = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              free_run_pin,
    input  logic              ref_present,
    input  logic              frame_tick,
    input  logic [FCNT_W-1:0] reacq_frames,
    input  logic              blank_ref,
    input  logic [OFS_W-1:0]  h_offset,
    input  logic [OFS_W-1:0]  sync_to_eav,
    input  logic              lock_mask_en,
    input  logic              raw_genlock,
    input  logic              raw_vlock,
    input  logic              raw_flock,
    input  logic              raw_audio_lock,
    output logic [1:0]        mode,
    output logic              line_advance,
    output logic [ST_W-1:0]   lock_status,
    output logic [OFS_W-1:0]  s2e_status
);
    gl_mode_e   mode_q;
    ofs_flags_t flags;

    gl_mode_fsm #(.FCNT_W(FCNT_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .free_pin     (free_run_pin),
        .ref_ok       (ref_present),
        .frame_tick   (frame_tick),
        .reacq_frames (reacq_frames),
        .mode_q       (mode_q)
    );

    gl_offset_cmp #(.OFS_W(OFS_W), .ADV_MARGIN(ADV_MARGIN)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .blank_ref (blank_ref),
        .mask_en   (lock_mask_en),
        .h_offset  (h_offset),
        .s2e       (sync_to_eav),
        .flags_q   (flags),
        .s2e_q     (s2e_status)
    );

    gl_status_pack u_pack (
        .mode           (mode_q),
        .sup            (flags.sup),
        .raw_genlock    (raw_genlock),
        .raw_vlock      (raw_vlock),
        .raw_flock      (raw_flock),
        .raw_audio_lock (raw_audio_lock),
        .status         (lock_status)
    );

    assign mode         = mode_q;
    assign line_advance = flags.adv;

endmodule

// File: rtl/gl_mode_ctrl_chk.sv
module gl_mode_ctrl_chk #(
    parameter int OFS_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             free_run_pin,
    input logic             ref_present,
    input logic [OFS_W-1:0] sync_to_eav,
    input logic [1:0]       mode,
    input logic             line_advance,
    input logic [7:0]       lock_status,
    input logic [OFS_W-1:0] s2e_status
);
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_seen === 1'b1 && !rst) begin
            reset_state_chk: assert (mode == 2'b10 && !line_advance && s2e_status == '0);
        end
    end

    // R2
    free_pin_chk: assert property (@(posedge clk) disable iff (rst)
        free_run_pin |=> mode == 2'b10);

    // R4
    ref_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && !free_run_pin && !ref_present) |=> mode == 2'b01);

    // R5
    no_early_relock_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && !ref_present) |=> mode != 2'b00);

    // R9
    lock_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00) |-> (!lock_status[3] && !lock_status[4] && !lock_status[0]));

    // R11
    s2e_echo_chk: assert property (@(posedge clk) disable iff (rst)
        !free_run_pin || free_run_pin |=> s2e_status == $past(sync_to_eav));

endmodule

bind gl_mode_ctrl gl_mode_ctrl_chk #(.OFS_W(OFS_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .free_run_pin (free_run_pin),
    .ref_present  (ref_present),
    .sync_to_eav  (sync_to_eav),
    .mode         (mode),
    .line_advance (line_advance),
    .lock_status  (lock_status),
    .s2e_status   (s2e_status)
);

// File: tb/tb_gl_mode_ctrl.sv
`timescale 1ns/1ps
module tb_gl_mode_ctrl;
    logic        clk = 0;
    logic        rst = 1;
    logic        free_run_pin = 1, ref_present = 0, frame_tick = 0;
    logic [7:0]  reacq_frames = 8'd3;
    logic        blank_ref = 0, lock_mask_en = 0;
    logic [12:0] h_offset = 0, sync_to_eav = 13'd100;
    logic        raw_genlock = 0, raw_vlock = 0, raw_flock = 0, raw_audio_lock = 0;
    logic [1:0]  mode;
    logic        line_advance;
    logic [7:0]  lock_status;
    logic [12:0] s2e_status;

    always #2 clk = ~clk;

    gl_mode_ctrl dut (.*);

    int total = 0, bad = 0;
    bit done = 0, chk_on = 0;

    // behavioural reference model
    int m_mode = 2, m_cnt = 0, m_s2e = 0;
    bit m_adv = 0, m_sup = 0;

    always @(posedge clk) begin
        int tgt;
        if (rst) begin
            m_mode = 2; m_cnt = 0; m_adv = 0; m_sup = 0; m_s2e = 0;
        end else begin
            m_adv = blank_ref && (int'(h_offset) > int'(sync_to_eav) + 20);
            m_sup = blank_ref && (int'(h_offset) == int'(sync_to_eav) + 21) && !lock_mask_en;
            m_s2e = sync_to_eav;
            tgt = (reacq_frames == 0) ? 1 : int'(reacq_frames);
            if (free_run_pin) begin m_mode = 2; m_cnt = 0; end
            else if (m_mode == 2) begin m_mode = 0; m_cnt = 0; end
            else if (m_mode == 0) begin m_cnt = 0; if (!ref_present) m_mode = 1; end
            else begin
                if (!ref_present) m_cnt = 0;
                else if (frame_tick) begin
                    m_cnt++;
                    if (m_cnt >= tgt) begin m_mode = 0; m_cnt = 0; end
                end
            end
        end
        chk_on = 1;
    end

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [7:0] es;
        if (chk_on && !done) begin
            es = '0;
            es[0] = raw_genlock && m_mode == 0;
            es[1] = (m_mode == 1);
            es[2] = raw_audio_lock;
            es[3] = raw_vlock && m_mode == 0 && !m_sup;
            es[4] = raw_flock && m_mode == 0 && !m_sup;
            chk("mode R2 R3 R4 R5", mode, m_mode);
            chk("line_advance R6", line_advance, m_adv);
            chk("lock bits 3/4 R7 R8 R9", lock_status[4:3], es[4:3]);
            chk("lock bits R9", {lock_status[7:5], lock_status[1:0]}, {es[7:5], es[1:0]});
            chk("audio bit R10", lock_status[2], es[2]);
            chk("s2e_status R11", s2e_status, m_s2e);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 0; #0;
        // R1: state right after reset
        chk("R1 reset mode", mode, 2);
        chk("R1 reset advance", line_advance, 0);
        cyc(2);
        // R10: audio bit follows raw flag in free run
        raw_audio_lock = 1; cyc(2);
        chk("R10 audio in free run", lock_status[2], 1);
        // R3: leave free run
        free_run_pin = 0; ref_present = 1; raw_genlock = 1; raw_vlock = 1; raw_flock = 1;
        cyc(1);
        chk("R3 to genlock", mode, 0);
        // R7/R6 same cycle at exact offset
        blank_ref = 1;
        for (int d = 19; d <= 23; d++) begin
            h_offset = sync_to_eav + 13'(d); cyc(1);
        end
        h_offset = sync_to_eav + 13'd21; cyc(1);
        chk("R7 vlock dropped", lock_status[3], 0);
        chk("R7 genlock kept", lock_status[0], 1);
        chk("R6 advance at +21", line_advance, 1);
        lock_mask_en = 1; cyc(1);
        chk("R8 masked vlock", lock_status[3], 1);
        chk("R8 masked flock", lock_status[4], 1);
        lock_mask_en = 0; blank_ref = 0; cyc(1);
        chk("R6 no advance without blank", line_advance, 0);
        // R4: reference loss
        ref_present = 0; cyc(1);
        chk("R4 freeze", mode, 1);
        // R5: reacquire with interruption
        ref_present = 1; reacq_frames = 3;
        for (int k = 0; k < 2; k++) begin frame_tick = 1; cyc(1); frame_tick = 0; cyc(1); end
        ref_present = 0; cyc(1); ref_present = 1;
        for (int k = 0; k < 2; k++) begin frame_tick = 1; cyc(1); frame_tick = 0; cyc(1); end
        chk("R5 still frozen", mode, 1);
        frame_tick = 1; cyc(1); frame_tick = 0;
        chk("R5 relocked", mode, 0);
        // R5 with zero count
        ref_present = 0; cyc(1); ref_present = 1; reacq_frames = 0; cyc(2);
        frame_tick = 1; cyc(1); frame_tick = 0;
        chk("R5 zero count acts as one", mode, 0);
        // R2 from freeze
        ref_present = 0; cyc(1);
        free_run_pin = 1; cyc(1);
        chk("R2 forced free run", mode, 2);
        free_run_pin = 0; ref_present = 1;
        // random mix
        for (int i = 0; i < 4000; i++) begin
            sync_to_eav    = 13'($urandom_range(0, 8191));
            h_offset       = sync_to_eav + 13'($urandom_range(17, 24));
            blank_ref      = ($urandom_range(0, 3) != 0);
            lock_mask_en   = ($urandom_range(0, 3) == 0);
            ref_present    = ($urandom_range(0, 7) != 0);
            free_run_pin   = ($urandom_range(0, 40) == 0);
            frame_tick     = ($urandom_range(0, 3) == 0);
            reacq_frames   = 8'($urandom_range(0, 3));
            raw_genlock    = 1'($urandom);
            raw_vlock      = 1'($urandom);
            raw_flock      = 1'($urandom);
            raw_audio_lock = 1'($urandom);
            cyc(1);
        end
        cyc(2);
        finish_run();
    end
endmodule